// File: doc/BRIEF.md
# Multi-mode down-counter timer

This block is a single 16-bit down-counting timer channel with one output pin. A host selects one of three waveforms through a mode register and gives the channel a count. The waveforms are a free-running square wave, a single low strobe started by writing the count, and a low strobe started by a rising edge on the gate input. All activity is synchronous to one clock. The host writes through a one-cycle write strobe that carries a select bit, which picks either the mode register or the count register.

In square-wave mode the count sets the period. The output is high for the larger half of the period and low for the smaller half. A low gate level freezes the wave.

Both strobe modes count the loaded value down and drop the output for one clock at terminal count. The gate-started variant restarts its countdown on every new gate rising edge. A count of zero stands for the largest count, 65536.

Top module: `tmr_chan`

## Requirements
- R1: After reset the output is high, the mode is square wave (code 0), and nothing counts until a count is written.
- R2: A write with `wr_sel`=1 takes the mode code from `wr_data[1:0]`: 0 square wave, 1 write-started strobe, 2 gate-started strobe. Code 3 is ignored, so the mode and the output run on as before. A valid mode write drives the output high on the next clock, stops any countdown and discards the stored count.
- R3: A write with `wr_sel`=0 stores count N = `wr_data`, where a value of 0 means N = 65536.
- R4: In square-wave mode, after a count write the output is high for ceil(N/2) counting clocks and then low for floor(N/2) counting clocks, repeating without end. N = 1 keeps the output high.
- R5: In square-wave mode, a clock edge at which `gate` is low does not count, and the output holds.
- R6: In square-wave mode, a count write during a running wave restarts the wave at the start of its high half from the next clock.
- R7: In write-started strobe mode, the output goes low for exactly one clock after the N-th clock edge following the count-write edge. It then stays high until the next count write. The `gate` input has no effect in this mode.
- R8: In write-started strobe mode, a count write during a countdown restarts the countdown with the new N. The pending strobe is cancelled.
- R9: In gate-started strobe mode, a count write only stores N. A gate rising edge, where `gate` is high at an edge and was low at the previous edge, starts a countdown. The output goes low for one clock after the N-th edge following the rising edge. A rising edge before any count has been written is ignored.
- R10: In gate-started strobe mode, a gate rising edge during a countdown restarts it from the stored N. This also holds at the very edge where terminal count would fall, and there the strobe is suppressed.
- R11: In gate-started strobe mode, when a count write and a gate rising edge fall on the same edge, the countdown starts from the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_sel | input | 1 | Write target: 1 mode register, 0 count register |
| wr_data | input | 16 | Write data: count value, or mode code in bits 1:0 |
| gate | input | 1 | Gate: level enable for the square wave, edge trigger for the gate-started strobe |
| out | output | 1 | Timer output waveform |

## Verification
Two functions of the gate-started strobe can fall on the same edge.

The first pair is a retrigger and the terminal count. The bench provokes it by holding `gate` low after a rising edge and raising it again exactly at the N-th edge. It is judged correct when the output stays high at that edge and the strobe appears N edges later instead.

The second pair is a count write and a gate rising edge on the same edge. The bench judges it by the strobe arriving after the newly written count, not the old one.

A behavioural model in the bench, built on a phase position and a countdown integer, predicts the output on every clock. Both collisions are therefore judged cycle by cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      TM_SQUARE   = 2'd0,
      TM_SWSTROBE = 2'd1,
      TM_HWSTROBE = 2'd2,
      TM_RSVD     = 2'd3
   } tmr_mode_e;

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge #(
   parameter logic RST_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   output logic rise
);
   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= RST_LVL;
      else        gate_q <= gate;
   end

   assign rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
   import tmr_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   output tmr_mode_e        mode,
   output logic             mode_wr,
   output logic             cnt_wr,
   output logic [WIDTH:0]   nval,
   output logic             have_val
);
   localparam int CW = WIDTH + 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("tmr_ctrl: WIDTH must be at least 2 to carry a mode code");
      end
   endgenerate

   logic [WIDTH-1:0] rl_q;
   logic             loaded_q;
   tmr_mode_e        code;

   function automatic logic [CW-1:0] eff_count(input logic [WIDTH-1:0] v);
      return {(v == '0), v};
   endfunction

   assign code    = tmr_mode_e'(wr_data[1:0]);
   assign mode_wr = wr_en & wr_sel & (code != TM_RSVD);
   assign cnt_wr  = wr_en & ~wr_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= TM_SQUARE;
         rl_q     <= '0;
         loaded_q <= 1'b0;
      end else if (mode_wr) begin
         mode     <= code;
         loaded_q <= 1'b0;
      end else if (cnt_wr) begin
         rl_q     <= wr_data;
         loaded_q <= 1'b1;
      end
   end

   assign nval     = cnt_wr ? eff_count(wr_data) : eff_count(rl_q);
   assign have_val = cnt_wr | loaded_q;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
   import tmr_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  tmr_mode_e      mode,
   input  logic           mode_wr,
   input  logic           cnt_wr,
   input  logic [WIDTH:0] nval,
   input  logic           have_val,
   input  logic           gate,
   input  logic           rise,
   output logic           out_o
);
   localparam int CW = WIDTH + 1;
   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] hi_half, lo_half;
   logic          phase_hi, run, armed, out_q, tc;

   assign hi_half = (nval + ONE) >> 1;
   assign lo_half = nval >> 1;
   assign tc      = (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         phase_hi <= 1'b1;
         run      <= 1'b0;
         armed    <= 1'b0;
         out_q    <= 1'b1;
      end else if (mode_wr) begin
         phase_hi <= 1'b1;
         run      <= 1'b0;
         armed    <= 1'b0;
         out_q    <= 1'b1;
      end else begin
         case (mode)
            TM_SQUARE: begin
               if (cnt_wr) begin
                  cnt      <= hi_half;
                  phase_hi <= 1'b1;
                  out_q    <= 1'b1;
                  run      <= 1'b1;
               end else if (run && gate) begin
                  if (tc) begin
                     if (phase_hi && (lo_half != '0)) begin
                        phase_hi <= 1'b0;
                        out_q    <= 1'b0;
                        cnt      <= lo_half;
                     end else begin
                        phase_hi <= 1'b1;
                        out_q    <= 1'b1;
                        cnt      <= hi_half;
                     end
                  end else begin
                     cnt <= cnt - ONE;
                  end
               end
            end
            TM_SWSTROBE, TM_HWSTROBE: begin
               if ((mode == TM_SWSTROBE) ? cnt_wr : (rise && have_val)) begin
                  cnt   <= nval;
                  armed <= 1'b1;
                  out_q <= 1'b1;
               end else begin
                  out_q <= 1'b1;
                  if (armed) begin
                     if (tc) begin
                        out_q <= 1'b0;
                        armed <= 1'b0;
                     end else begin
                        cnt <= cnt - ONE;
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign out_o = out_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             gate,
   output logic             out
);
   tmr_mode_e      mode;
   logic           mode_wr, cnt_wr, have_val, rise;
   logic [WIDTH:0] nval;

   tmr_gate_edge #(.RST_LVL(1'b0)) u_gate (
      .clk  (clk),
      .rst_n(rst_n),
      .gate (gate),
      .rise (rise)
   );

   tmr_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .mode    (mode),
      .mode_wr (mode_wr),
      .cnt_wr  (cnt_wr),
      .nval    (nval),
      .have_val(have_val)
   );

   tmr_core #(.WIDTH(WIDTH)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .mode_wr (mode_wr),
      .cnt_wr  (cnt_wr),
      .nval    (nval),
      .have_val(have_val),
      .gate    (gate),
      .rise    (rise),
      .out_o   (out)
   );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int WIDTH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             wr_sel,
   input logic [WIDTH-1:0] wr_data,
   input logic             gate,
   input logic             out,
   input logic [1:0]       mode,
   input logic             have_val
);
   assert_reset_high_R1: assert property (@(posedge clk) !rst_n |=> out);

   assert_mode_write_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_data[1:0] != 2'd3) |=> out);

   assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && wr_data[1:0] == 2'd3) |=> $stable(mode));

   assert_sq_gate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !gate && !wr_en) |=> $stable(out));

   assert_sq_load_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && wr_en && !wr_sel) |=> out);

   assert_strobe_one_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && !out) |=> out);

   assert_hw_needs_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && !have_val) |=> out);
endmodule

bind tmr_chan tmr_chan_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .gate    (gate),
   .out     (out),
   .mode    (mode),
   .have_val(have_val)
);

// File: tb/sim_tmr_chan.sv
`timescale 1ns/1ps
module sim_tmr_chan;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        gate = 1'b0;
   logic        out;

   int    vectors = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int mmode = 0, mN = 0, pos = 0, tleft = 0;
   bit mloaded = 0, mrun = 0, marmed = 0, mlow = 0, prevg = 0, m_out = 1;

   tmr_chan #(.WIDTH(16)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .gate(gate), .out(out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mmode = 0; mN = 0; pos = 0; tleft = 0;
         mloaded = 0; mrun = 0; marmed = 0; mlow = 0; prevg = 0; m_out = 1;
      end else begin
         bit rise, wcount, wmode;
         rise   = gate && !prevg;
         prevg  = gate;
         wcount = wr_en && !wr_sel;
         wmode  = wr_en && wr_sel && (wr_data[1:0] != 2'd3);
         if (wcount) begin
            mN = (wr_data == 0) ? 65536 : int'(wr_data);
            mloaded = 1;
         end
         if (wmode) begin
            mmode = int'(wr_data[1:0]);
            mloaded = 0; mrun = 0; marmed = 0; mlow = 0; pos = 0;
         end else if (mmode == 0) begin
            if (wcount) begin pos = 0; mrun = 1; end
            else if (mrun && gate) pos = (pos + 1) % mN;
         end else begin
            bit start;
            mlow = 0;
            start = (mmode == 1) ? wcount : (rise && mloaded);
            if (start) begin tleft = mN; marmed = 1; end
            else if (marmed) begin
               tleft = tleft - 1;
               if (tleft == 0) begin mlow = 1; marmed = 0; end
            end
         end
         if (mmode == 0) m_out = !mrun || (pos < (mN + 1) / 2);
         else            m_out = !mlow;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         if (out !== m_out) begin
            errors++;
            $display("FAIL %s: out=%0b expected %0b at %0t", cur_req, out, m_out, $time);
         end
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input bit sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic gate_set(input bit v, input int n);
      @(negedge clk);
      gate = v;
      idle(n);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 250000);
      errors++;
      $display("FAIL watchdog: out=%0b expected end of run", out);
      finish_run();
   end

   initial begin
      // R1 reset state and idle without a count
      cur_req = "R1";
      idle(3);
      if (out !== 1'b1) begin
         errors++;
         $display("FAIL R1: out=%0b expected 1 during reset", out);
      end
      vectors++;
      rst_n = 1'b1;
      gate = 1'b1;
      idle(6);

      // R4 odd, even and unit counts
      cur_req = "R4";
      wr(1'b0, 16'd5); idle(20);
      cur_req = "R6";
      wr(1'b0, 16'd6); idle(4);
      wr(1'b0, 16'd6); idle(20);
      cur_req = "R4";
      wr(1'b0, 16'd1); idle(6);
      wr(1'b0, 16'd7); idle(3);

      // R5 gate low suspends the wave
      cur_req = "R5";
      gate_set(1'b0, 5);
      gate_set(1'b1, 6);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); gate = ~gate;
      end
      gate_set(1'b1, 5);

      // R2 reserved code ignored, then switch to write-started strobe
      cur_req = "R2";
      wr(1'b1, 16'd3); idle(8);
      wr(1'b1, 16'd1); idle(4);

      // R7 strobe with gate toggling (ignored)
      cur_req = "R7";
      wr(1'b0, 16'd4);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); gate = ~gate;
      end
      wr(1'b0, 16'd1); idle(4);

      // R8 reload mid countdown
      cur_req = "R8";
      wr(1'b0, 16'd6); idle(2);
      wr(1'b0, 16'd3); idle(8);

      // R2 mode write mid countdown cancels it
      cur_req = "R2";
      wr(1'b0, 16'd5); idle(1);
      wr(1'b1, 16'd1); idle(8);

      // R3 zero means the largest count
      cur_req = "R3";
      wr(1'b0, 16'd0); idle(65540);

      // R9 gate-started strobe
      cur_req = "R9";
      wr(1'b1, 16'd2);
      gate_set(1'b0, 2);
      gate_set(1'b1, 3);
      gate_set(1'b0, 2);
      wr(1'b0, 16'd4); idle(3);
      gate_set(1'b1, 8);
      gate_set(1'b0, 2);

      // R10 retrigger mid count and at terminal count
      cur_req = "R10";
      gate_set(1'b1, 2);
      gate_set(1'b0, 1);
      gate_set(1'b1, 8);
      gate_set(1'b0, 2);
      @(negedge clk); gate = 1'b1;   // rising edge at next posedge (e0)
      @(negedge clk); gate = 1'b0;   // low for e1..e3
      idle(2);
      @(negedge clk); gate = 1'b1;   // rise lands on e4, the terminal edge
      idle(8);
      gate_set(1'b0, 2);

      // R11 count write and gate rise on the same edge
      cur_req = "R11";
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'd3; gate = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      idle(8);

      finish_run();
   end
endmodule